// File: doc/BRIEF.md
# Masked Burst Address Generator

This block produces the access address for one port of a synchronous memory. It holds three registers. The counter supplies the current address. The mask marks which low-order counter bits may change. The mirror keeps the start address of the current burst. Four active-low control inputs are sampled on each rising clock edge and pick one operation: load, increment, hold, counter clear, mask load, mask clear, or readback of either the counter or the mask.

In a burst, software loads a start address once, and the counter then steps through the unmasked field on each increment. When the field is used up, the counter returns to the address saved in the mirror, so the same block of memory can be read again without a new load. An active-low interrupt output goes low when an increment leaves the unmasked field at all ones. This warns that the next increment will wrap. Readback returns the counter or the mask one clock after the request, and a valid strobe marks it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the counter and mirror to zero, sets the mask to all ones, drives `cnt_int_n` high and `rb_valid` low.
- R2: Load (`msk_sel_n`=1, `clr_n`=1, `strobe_n`=0, `step_n`=0) copies `addr_in` into both the counter and the mirror and drives `cnt_int_n` high.
- R3: Increment (`msk_sel_n`=1, `clr_n`=1, `strobe_n`=1, `step_n`=0) adds to the unmasked field only and leaves the masked (mask bit 0) counter bits unchanged.
- R4: The increment step is 1 when mask bit 0 is 1, and 2 when mask bit 0 is 0. In the second case counter bit 0 keeps its value.
- R5: `cnt_int_n` goes low after an increment that leaves every unmasked counter bit at 1. It goes high after an increment that gives any other value.
- R6: An increment that starts with the unmasked field at all ones loads the counter from the mirror.
- R7: Counter clear (`msk_sel_n`=1, `clr_n`=0) sets the unmasked counter bits to 0, keeps the masked bits, copies the result into the mirror and drives `cnt_int_n` high.
- R8: With `msk_sel_n`=0, `clr_n`=0 sets the mask to all ones. With `msk_sel_n`=0, `clr_n`=1, `strobe_n`=0, `step_n`=0 the mask is loaded from `addr_in`. Both operations drive `cnt_int_n` high and leave the counter and the mirror unchanged.
- R9: Readback (`clr_n`=1, `strobe_n`=0, `step_n`=1) puts the counter (`msk_sel_n`=1) or the mask (`msk_sel_n`=0) on `rb_data` after the next clock edge. `rb_valid` is high for exactly those cycles.
- R10: Hold (all four controls high) and the reserved code (`msk_sel_n`=0, `clr_n`=1, `strobe_n`=1, `step_n`=0) leave the counter, mask, mirror and `cnt_int_n` unchanged.
- R11: `clr_n`=0 takes priority over `strobe_n` and `step_n`. `strobe_n`=0 with `step_n`=1 performs a readback, not a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msk_sel_n | input | 1 | Low: the operation targets the mask |
| clr_n | input | 1 | Low: clear operation |
| strobe_n | input | 1 | Low: address strobe |
| step_n | input | 1 | Low: counter enable |
| addr_in | input | ADDR_W | External address or mask value |
| addr_out | output | ADDR_W | Current counter value |
| cnt_int_n | output | 1 | Active-low field-exhausted flag |
| rb_data | output | ADDR_W | Readback value |
| rb_valid | output | 1 | High when rb_data carries a readback |

## Verification
A wrong mask value does not show on `addr_out` right away. It appears at the first increment, as a changed high-order bit or a wrong step size. It also appears on a mask readback one cycle after the request. A wrong mirror stays hidden until the increment after `cnt_int_n` falls, when the counter returns to the wrong start address. For this reason the bench runs bursts to the point of wrapping after every load, counter clear and mask change. A cycle-accurate model runs alongside the design and compares the outputs on every clock, which catches each difference in the cycle it first becomes visible.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [3:0] {
    OP_HOLD,
    OP_LOAD,
    OP_INCR,
    OP_CCLR,
    OP_CRB,
    OP_MCLR,
    OP_MLOAD,
    OP_MRB,
    OP_RSVD
  } bag_op_e;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import bag_pkg::*;
(
  input  logic    msk_sel_n,
  input  logic    clr_n,
  input  logic    strobe_n,
  input  logic    step_n,
  output bag_op_e op
);
  always_comb begin
    if (msk_sel_n) begin
      if (!clr_n)                   op = OP_CCLR;
      else if (!strobe_n && !step_n) op = OP_LOAD;
      else if (!strobe_n)           op = OP_CRB;
      else if (!step_n)             op = OP_INCR;
      else                          op = OP_HOLD;
    end else begin
      if (!clr_n)                   op = OP_MCLR;
      else if (!strobe_n && !step_n) op = OP_MLOAD;
      else if (!strobe_n)           op = OP_MRB;
      else if (!step_n)             op = OP_RSVD;
      else                          op = OP_HOLD;
    end
  end
endmodule

// File: rtl/bag_regs.sv
module bag_regs
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  bag_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              int_n_q
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] mirror_q;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] inc_val;
  logic              field_full;
  logic              inc_full;

  // increment path: add the step, keep masked bits, wrap to mirror when exhausted
  always_comb begin
    step       = mask_q[0] ? STEP_ONE : STEP_TWO;
    sum        = cnt_q + step;
    field_full = ((cnt_q & mask_q) == mask_q);
    inc_val    = field_full ? mirror_q : ((cnt_q & ~mask_q) | (sum & mask_q));
    inc_full   = ((inc_val & mask_q) == mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mirror_q <= '0;
      mask_q   <= ALL_ONES;
      int_n_q  <= 1'b1;
    end else begin
      unique case (op)
        OP_LOAD: begin
          cnt_q    <= addr_in;
          mirror_q <= addr_in;
          int_n_q  <= 1'b1;
        end
        OP_INCR: begin
          cnt_q   <= inc_val;
          int_n_q <= ~inc_full;
        end
        OP_CCLR: begin
          cnt_q    <= cnt_q & ~mask_q;
          mirror_q <= cnt_q & ~mask_q;
          int_n_q  <= 1'b1;
        end
        OP_MCLR: begin
          mask_q  <= ALL_ONES;
          int_n_q <= 1'b1;
        end
        OP_MLOAD: begin
          mask_q  <= addr_in;
          int_n_q <= 1'b1;
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/bag_readback.sv
module bag_readback
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  bag_op_e           op,
  input  logic [ADDR_W-1:0] cnt_q,
  input  logic [ADDR_W-1:0] mask_q,
  output logic [ADDR_W-1:0] rb_data,
  output logic              rb_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rb_data  <= '0;
      rb_valid <= 1'b0;
    end else begin
      rb_valid <= (op == OP_CRB) || (op == OP_MRB);
      if (op == OP_CRB)      rb_data <= cnt_q;
      else if (op == OP_MRB) rb_data <= mask_q;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msk_sel_n,
  input  logic              clr_n,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              cnt_int_n,
  output logic [ADDR_W-1:0] rb_data,
  output logic              rb_valid
);
  bag_op_e           op;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] mask_q;

  bag_decode u_decode (
    .msk_sel_n (msk_sel_n),
    .clr_n     (clr_n),
    .strobe_n  (strobe_n),
    .step_n    (step_n),
    .op        (op)
  );

  bag_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .addr_in (addr_in),
    .cnt_q   (cnt_q),
    .mask_q  (mask_q),
    .int_n_q (cnt_int_n)
  );

  bag_readback #(.ADDR_W(ADDR_W)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .cnt_q    (cnt_q),
    .mask_q   (mask_q),
    .rb_data  (rb_data),
    .rb_valid (rb_valid)
  );

  assign addr_out = cnt_q;
endmodule

// File: rtl/burst_addr_gen_checker.sv
module burst_addr_gen_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              msk_sel_n,
  input logic              clr_n,
  input logic              strobe_n,
  input logic              step_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              cnt_int_n,
  input logic [ADDR_W-1:0] rb_data,
  input logic              rb_valid
);
  logic is_load, is_incr, is_cclr, is_hold, is_rb, is_crb, is_mwrite, is_rsvd;
  always_comb begin
    is_load   = msk_sel_n && clr_n && !strobe_n && !step_n;
    is_incr   = msk_sel_n && clr_n && strobe_n && !step_n;
    is_cclr   = msk_sel_n && !clr_n;
    is_hold   = msk_sel_n && clr_n && strobe_n && step_n;
    is_rb     = clr_n && !strobe_n && step_n;
    is_crb    = is_rb && msk_sel_n;
    is_mwrite = !msk_sel_n && (!clr_n || (!strobe_n && !step_n));
    is_rsvd   = !msk_sel_n && clr_n && strobe_n && !step_n;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && cnt_int_n && !rb_valid);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    is_load |=> (addr_out == $past(addr_in)) && cnt_int_n);

  assert_int_source_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cnt_int_n) |-> $past(is_incr));

  assert_clear_subset_R7: assert property (@(posedge clk) disable iff (rst)
    is_cclr |=> ((addr_out & ~$past(addr_out)) == '0) && cnt_int_n);

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
    is_mwrite |=> $stable(addr_out) && cnt_int_n);

  assert_rb_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    is_rb |=> rb_valid);

  assert_rb_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !is_rb |=> !rb_valid);

  assert_crb_value_R9: assert property (@(posedge clk) disable iff (rst)
    is_crb |=> (rb_data == $past(addr_out)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (is_hold || is_rsvd) |=> $stable(addr_out) && $stable(cnt_int_n));
endmodule

bind burst_addr_gen burst_addr_gen_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .msk_sel_n (msk_sel_n),
  .clr_n     (clr_n),
  .strobe_n  (strobe_n),
  .step_n    (step_n),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .cnt_int_n (cnt_int_n),
  .rb_data   (rb_data),
  .rb_valid  (rb_valid)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int W = 17;
  localparam int unsigned FULL = (32'd1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         msk_sel_n = 1'b1, clr_n = 1'b1, strobe_n = 1'b1, step_n = 1'b1;
  logic [W-1:0] addr_in = '0;
  logic [W-1:0] addr_out, rb_data;
  logic         cnt_int_n, rb_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_burst_addr_gen (
    .clk(clk), .rst(rst), .msk_sel_n(msk_sel_n), .clr_n(clr_n),
    .strobe_n(strobe_n), .step_n(step_n), .addr_in(addr_in),
    .addr_out(addr_out), .cnt_int_n(cnt_int_n),
    .rb_data(rb_data), .rb_valid(rb_valid)
  );

  // behavioural reference model, field arithmetic on integers
  int unsigned m_cnt, m_msk, m_mir, m_rbd;
  bit          m_int_n, m_rbv;

  function automatic int count_ones(int unsigned v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_mir = 0; m_msk = FULL; m_int_n = 1; m_rbv = 0; m_rbd = 0;
    end else begin
      int unsigned lo, fm, f;
      m_rbv = 0;
      lo = m_msk[0] ? 0 : 1;
      fm = (count_ones(m_msk) >= 32) ? 32'hFFFF_FFFF : ((32'd1 << count_ones(m_msk)) - 1);
      if (msk_sel_n) begin
        if (!clr_n) begin
          m_cnt = m_cnt & ~m_msk & FULL; m_mir = m_cnt; m_int_n = 1;
        end else if (!strobe_n && !step_n) begin
          m_cnt = addr_in; m_mir = addr_in; m_int_n = 1;
        end else if (!strobe_n) begin
          m_rbv = 1; m_rbd = m_cnt;
        end else if (!step_n) begin
          f = (m_cnt >> lo) & fm;
          if (f == fm) m_cnt = m_mir;
          else m_cnt = ((m_cnt & ~(fm << lo)) | ((f + 1) << lo)) & FULL;
          m_int_n = !(((m_cnt >> lo) & fm) == fm);
        end
      end else begin
        if (!clr_n) begin
          m_msk = FULL; m_int_n = 1;
        end else if (!strobe_n && !step_n) begin
          m_msk = addr_in; m_int_n = 1;
        end else if (!strobe_n) begin
          m_rbv = 1; m_rbd = m_msk;
        end
      end
    end
  end

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 addr_out vs model", addr_out, m_cnt);
      chk("R5 cnt_int_n vs model", cnt_int_n, m_int_n);
      chk("R9 rb_valid vs model", rb_valid, m_rbv);
      if (m_rbv) chk("R9 rb_data vs model", rb_data, m_rbd);
    end
  end

  task automatic step(input bit ms, input bit cr, input bit st, input bit ce,
                      input int unsigned a);
    @(negedge clk);
    msk_sel_n = ms; clr_n = cr; strobe_n = st; step_n = ce; addr_in = a[W-1:0];
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr after reset", addr_out, 0);
    chk("R1 int after reset", cnt_int_n, 1);
    chk("R1 rb_valid after reset", rb_valid, 0);
    @(negedge clk); rst = 0;
    step(0, 1, 0, 1, 0);
    chk("R1 mask after reset", rb_data, FULL);

    // window 0x3F starting at 0x08
    step(0, 1, 0, 0, 'h3F);
    step(1, 1, 0, 0, 'h08);
    chk("R2 load", addr_out, 'h08);
    step(1, 1, 1, 0, 0);
    chk("R3 first increment", addr_out, 'h09);
    for (int i = 0; i < 54; i++) step(1, 1, 1, 0, 0);
    chk("R5 top of field addr", addr_out, 'h3F);
    chk("R5 int low at all ones", cnt_int_n, 0);
    step(1, 1, 1, 0, 0);
    chk("R6 wrap to mirror", addr_out, 'h08);
    chk("R5 int high after wrap", cnt_int_n, 1);

    // masked high bits are kept
    step(1, 1, 0, 0, 'h12348);
    step(1, 1, 1, 0, 0);
    chk("R3 masked bits kept", addr_out, 'h12349);
    for (int i = 0; i < 55; i++) step(1, 1, 1, 0, 0);
    chk("R6 wrap keeps high bits", addr_out, 'h12348);

    // step of two
    step(0, 1, 0, 0, 'h3E);
    step(1, 1, 0, 0, 'h11);
    step(1, 1, 1, 0, 0);
    chk("R4 step two keeps bit0", addr_out, 'h13);
    for (int i = 0; i < 22; i++) step(1, 1, 1, 0, 0);
    chk("R4 top with step two", addr_out, 'h3F);
    chk("R5 int low step two", cnt_int_n, 0);
    step(1, 1, 1, 0, 0);
    chk("R6 wrap step two", addr_out, 'h11);

    // counter clear updates mirror
    step(0, 1, 0, 0, 'h0F);
    step(1, 1, 0, 0, 'h1234);
    step(1, 1, 1, 0, 0);
    step(1, 0, 1, 1, 0);
    chk("R7 clear unmasked", addr_out, 'h1230);
    chk("R7 int high", cnt_int_n, 1);
    for (int i = 0; i < 15; i++) step(1, 1, 1, 0, 0);
    chk("R5 int low 0x123F", cnt_int_n, 0);
    step(0, 1, 0, 0, 'h0F);
    chk("R8 mask load keeps counter", addr_out, 'h123F);
    chk("R8 mask load clears int", cnt_int_n, 1);
    step(1, 1, 1, 0, 0);
    chk("R7 wrap to cleared value", addr_out, 'h1230);

    // mask clear and readback
    step(0, 0, 1, 1, 0);
    chk("R8 mask clear keeps counter", addr_out, 'h1230);
    step(0, 1, 0, 1, 0);
    chk("R9 mask readback", rb_data, FULL);
    chk("R9 valid on mask readback", rb_valid, 1);
    step(1, 1, 0, 1, 0);
    chk("R9 counter readback", rb_data, 'h1230);
    step(1, 1, 1, 1, 0);
    chk("R9 valid drops", rb_valid, 0);
    chk("R10 hold", addr_out, 'h1230);
    step(0, 1, 1, 0, 'h5);
    chk("R10 reserved addr", addr_out, 'h1230);
    step(0, 1, 0, 1, 0);
    chk("R10 reserved keeps mask", rb_data, FULL);

    // priority of clear and of readback over load
    step(1, 0, 0, 0, 'h55);
    chk("R11 clear wins", addr_out, 0);
    step(1, 1, 0, 1, 'h77);
    chk("R11 readback not load", addr_out, 0);

    // random legal traffic, checked by the model each clock
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      int unsigned a = $urandom & FULL;
      bit [3:0] c;
      case (r)
        0: c = 4'b1000; 1: c = 4'b1100; 2: c = 4'b1101;
        3, 4, 5: c = 4'b1110; 6: c = 4'b1111; 7: c = 4'b0000;
        8: c = 4'b0100; default: c = 4'b0101;
      endcase
      if (c == 4'b0100) begin
        int unsigned s = $urandom_range(0, 1);
        int unsigned n = $urandom_range(1, W - s);
        a = ((32'd1 << n) - 1) << s;
      end
      step(c[3], c[2], c[1], c[0], a);
    end
    @(negedge clk);
    finish_run();
  end
endmodule